// File: doc/BRIEF.md
# Compressed Instruction Expander

This is a purely combinational unit that sits between instruction alignment and decode in a 32-bit RISC-V core. It takes a 32-bit fetch word. If the two low bits are not both ones, the low 16 bits are a compressed parcel. The unit rewrites that parcel as the equivalent full-width base-integer instruction, so the decoder downstream only ever sees 32-bit formats. A fetch word whose low two bits are `11` is already a full instruction and passes through unchanged.

The unit handles the RV32 integer compressed subset:

- stack-relative and register-relative word loads and stores;
- immediate and register-register arithmetic, logic and shifts;
- jumps, jump-and-link, and branches that compare against zero;
- register moves, register adds and the breakpoint.

For each of these it reassembles the scrambled immediate bit positions, widens 3-bit register fields to x8..x15, and settles overlapping encodings in a fixed order. Reserved, unsupported and wider-architecture encodings raise an illegal flag. When the flag is raised, the output carries the raw 16-bit parcel zero-extended, so a trap handler can report it.

Top module: `rvc_expander`

## Requirements
- R1: When `fetch_i[1:0]` is `11`, `instr_o` equals `fetch_i` and `illegal_o` is low. Otherwise bits 31:16 of `fetch_i` have no effect on either output.
- R2: Whenever `illegal_o` is high, `instr_o` is `{16'h0, fetch_i[15:0]}`. The all-zero parcel is illegal.
- R3: A 3-bit register field f in the parcel names register 8+f. In the expanded word such a register appears as `5'b01fff`.
- R4: Quadrant 00, function 000 becomes `addi rd', x2, uimm`, with uimm[5:4] taken from bits 12:11, uimm[9:6] from 10:7, uimm[2] from 6 and uimm[3] from 5, zero-extended. A zero uimm is illegal.
- R5: Quadrant 00, function 010 is `lw` and function 110 is `sw`. Both use base rs1' in bits 9:7 and data register rd'/rs2' in bits 4:2. The offset takes uimm[5:3] from bits 12:10, uimm[2] from bit 6 and uimm[6] from bit 5.
- R6: Quadrant 01 functions 000 (`addi rd,rd`), 010 (`addi rd,x0`) and 100 with bits 11:10 = 10 (`andi rd',rd'`) use the immediate {bit12, bits 6:2}, sign-extended. Function 010 with rd = 0 is illegal.
- R7: Quadrant 01 functions 001 and 101 become `jal` with rd = x1 and rd = x0 respectively. The offset comes from bits 12:2 in the order imm[11|4|9:8|10|6|7|3:1|5] and is sign-extended.
- R8: Quadrant 01 functions 110 and 111 become `beq rs1', x0` and `bne rs1', x0`. The offset takes imm[8|4:3] from bits 12:10 and imm[7:6|2:1|5] from bits 6:2, and is sign-extended.
- R9: Quadrant 01, function 011 with rd = 2 becomes `addi x2, x2, imm`, with imm[9|4|6|8:7|5] taken from bits 12, 6, 5, 4:3 and 2; a zero immediate is illegal. With any other rd it becomes `lui rd, sext({bit12, bits 6:2})`, which is illegal when rd = 0 or the immediate is 0.
- R10: Quadrant 01, function 100 with bits 11:10 = 00 or 01 becomes `srli` or `srai` on rs1'. Quadrant 10, function 000 becomes `slli rd, rd`. The shift amount is bits 6:2. Bit 12 set is illegal for all three, and `slli` with rd = 0 is illegal.
- R11: Quadrant 01, function 100 with bits 11:10 = 11 and bit 12 clear selects `sub`, `xor`, `or` or `and` from bits 6:5 = 00, 01, 10, 11, as `op rd', rd', rs2'`. With bit 12 set it is illegal.
- R12: Quadrant 10, function 100 resolves in this order:
  - bit12 = 0 with rs2 = 0 gives `jalr x0, 0(rs1)`;
  - bit12 = 0 otherwise gives `add rd, x0, rs2`;
  - bit12 = 1 with rs1 = rs2 = 0 gives `ebreak`;
  - bit12 = 1 with only rs2 = 0 gives `jalr x1, 0(rs1)`;
  - bit12 = 1 otherwise gives `add rd, rd, rs2`.
- R13: Quadrant 10, function 010 becomes `lw rd, uimm(x2)`, with uimm[5] from bit 12, uimm[4:2] from bits 6:4 and uimm[7:6] from bits 3:2. Function 110 becomes `sw rs2, uimm(x2)`, with uimm[5:2] from bits 12:9 and uimm[7:6] from bits 8:7.
- R14: Quadrant 00 functions other than 000, 010 and 110, and quadrant 10 functions 001, 011, 101 and 111, are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetch_i | input | 32 | Aligned fetch word; a compressed parcel occupies bits 15:0 |
| instr_o | output | 32 | Expanded or passed-through instruction, or the raw parcel when illegal |
| illegal_o | output | 1 | High when the parcel is reserved or not supported |

## Verification
The unit holds no state. A wrong internal choice therefore shows at the ports on the same input: a misplaced immediate bit, a wrong register offset or a wrong overlap order changes `instr_o` for exactly the parcels that reach that path. Each faulty path is exposed the moment one such parcel is applied. The bench therefore picks parcels whose immediate bits are asymmetric, so that any swapped pair of bit positions changes the expected word. It also sweeps every 16-bit parcel to confirm that an illegal result always returns the raw parcel and a legal one always carries a full-width opcode.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

    localparam int ILEN  = 32;
    localparam int CLEN  = 16;
    localparam int RIDX  = 5;
    localparam int PADW  = ILEN - CLEN;

    typedef logic [6:0]      opc_t;
    typedef logic [2:0]      f3_t;
    typedef logic [RIDX-1:0] reg_t;
    typedef logic [ILEN-1:0] word_t;

    localparam opc_t OPC_LOAD   = 7'b0000011;
    localparam opc_t OPC_IMM    = 7'b0010011;
    localparam opc_t OPC_STORE  = 7'b0100011;
    localparam opc_t OPC_REG    = 7'b0110011;
    localparam opc_t OPC_LUI    = 7'b0110111;
    localparam opc_t OPC_BRANCH = 7'b1100011;
    localparam opc_t OPC_JALR   = 7'b1100111;
    localparam opc_t OPC_JAL    = 7'b1101111;
    localparam opc_t OPC_SYS    = 7'b1110011;

    localparam f3_t F3_ADD  = 3'b000;
    localparam f3_t F3_SLL  = 3'b001;
    localparam f3_t F3_WORD = 3'b010;
    localparam f3_t F3_XOR  = 3'b100;
    localparam f3_t F3_SR   = 3'b101;
    localparam f3_t F3_OR   = 3'b110;
    localparam f3_t F3_AND  = 3'b111;
    localparam f3_t F3_BEQ  = 3'b000;
    localparam f3_t F3_BNE  = 3'b001;

    localparam reg_t REG_ZERO = 5'd0;
    localparam reg_t REG_LINK = 5'd1;
    localparam reg_t REG_SP   = 5'd2;

    localparam word_t WORD_BREAK = 32'h0010_0073;

    // widen a 3-bit register field into the x8..x15 window
    function automatic reg_t widen_reg(input logic [2:0] f);
        return {2'b01, f};
    endfunction

    function automatic word_t build_i(input logic [11:0] imm, input reg_t rs1,
                                      input f3_t f3, input reg_t rd, input opc_t op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic word_t build_s(input logic [11:0] imm, input reg_t rs2,
                                      input reg_t rs1, input f3_t f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
    endfunction

    function automatic word_t build_r(input logic [6:0] f7, input reg_t rs2,
                                      input reg_t rs1, input f3_t f3, input reg_t rd);
        return {f7, rs2, rs1, f3, rd, OPC_REG};
    endfunction

    function automatic word_t build_b(input logic [12:0] imm, input reg_t rs1, input f3_t f3);
        return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
    endfunction

    function automatic word_t build_j(input logic [20:0] imm, input reg_t rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
    endfunction

    function automatic word_t build_u(input logic [19:0] imm, input reg_t rd);
        return {imm, rd, OPC_LUI};
    endfunction

endpackage

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec
    import rvc_pkg::*;
(
    input  logic [15:2] c,
    output word_t       word_o,
    output logic        bad_o
);

    logic [9:0]  spn_imm;
    logic [6:0]  mem_imm;
    reg_t        rp_hi;
    reg_t        rp_lo;

    always_comb begin
        spn_imm = {c[10:7], c[12:11], c[5], c[6], 2'b00};
        mem_imm = {c[5], c[12:10], c[6], 2'b00};
        rp_hi   = widen_reg(c[9:7]);
        rp_lo   = widen_reg(c[4:2]);
    end

    always_comb begin
        word_o = '0;
        bad_o  = 1'b0;
        unique case (c[15:13])
            3'b000: begin
                word_o = build_i({2'b00, spn_imm}, REG_SP, F3_ADD, rp_lo, OPC_IMM);
                bad_o  = (spn_imm == '0);
            end
            3'b010: word_o = build_i({5'b0, mem_imm}, rp_hi, F3_WORD, rp_lo, OPC_LOAD);
            3'b110: word_o = build_s({5'b0, mem_imm}, rp_lo, rp_hi, F3_WORD);
            default: bad_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec
    import rvc_pkg::*;
(
    input  logic [15:2] c,
    output word_t       word_o,
    output logic        bad_o
);

    logic [11:0] imm6;
    logic [11:0] imm_sp;
    logic [19:0] imm_up;
    logic [20:0] imm_jmp;
    logic [12:0] imm_br;
    logic        imm_zero;
    reg_t        rd;
    reg_t        rp_hi;
    reg_t        rp_lo;
    logic [6:0]  f7_alu;
    f3_t         f3_alu;

    always_comb begin
        rd       = c[11:7];
        rp_hi    = widen_reg(c[9:7]);
        rp_lo    = widen_reg(c[4:2]);
        imm_zero = ({c[12], c[6:2]} == 6'd0);
        imm6     = {{6{c[12]}}, c[12], c[6:2]};
        imm_sp   = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'b0000};
        imm_up   = {{14{c[12]}}, c[12], c[6:2]};
        imm_jmp  = {{10{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
        imm_br   = {{5{c[12]}}, c[6:5], c[2], c[11:10], c[4:3], 1'b0};
    end

    // register-register selector for bits 6:5
    always_comb begin
        f7_alu = 7'b0000000;
        unique case (c[6:5])
            2'b00: begin f3_alu = F3_ADD; f7_alu = 7'b0100000; end
            2'b01: f3_alu = F3_XOR;
            2'b10: f3_alu = F3_OR;
            default: f3_alu = F3_AND;
        endcase
    end

    always_comb begin
        word_o = '0;
        bad_o  = 1'b0;
        unique case (c[15:13])
            3'b000: word_o = build_i(imm6, rd, F3_ADD, rd, OPC_IMM);
            3'b001: word_o = build_j(imm_jmp, REG_LINK);
            3'b010: begin
                word_o = build_i(imm6, REG_ZERO, F3_ADD, rd, OPC_IMM);
                bad_o  = (rd == REG_ZERO);
            end
            3'b011: begin
                if (rd == REG_SP) begin
                    word_o = build_i(imm_sp, REG_SP, F3_ADD, REG_SP, OPC_IMM);
                    bad_o  = imm_zero;
                end else begin
                    word_o = build_u(imm_up, rd);
                    bad_o  = imm_zero || (rd == REG_ZERO);
                end
            end
            3'b100: begin
                unique case (c[11:10])
                    2'b00: begin
                        word_o = build_i({7'b0000000, c[6:2]}, rp_hi, F3_SR, rp_hi, OPC_IMM);
                        bad_o  = c[12];
                    end
                    2'b01: begin
                        word_o = build_i({7'b0100000, c[6:2]}, rp_hi, F3_SR, rp_hi, OPC_IMM);
                        bad_o  = c[12];
                    end
                    2'b10: word_o = build_i(imm6, rp_hi, F3_AND, rp_hi, OPC_IMM);
                    default: begin
                        word_o = build_r(f7_alu, rp_lo, rp_hi, f3_alu, rp_hi);
                        bad_o  = c[12];
                    end
                endcase
            end
            3'b101: word_o = build_j(imm_jmp, REG_ZERO);
            3'b110: word_o = build_b(imm_br, rp_hi, F3_BEQ);
            default: word_o = build_b(imm_br, rp_hi, F3_BNE);
        endcase
    end

endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec
    import rvc_pkg::*;
(
    input  logic [15:2] c,
    output word_t       word_o,
    output logic        bad_o
);

    reg_t        rd;
    reg_t        rs2;
    logic [7:0]  ld_imm;
    logic [7:0]  st_imm;

    always_comb begin
        rd     = c[11:7];
        rs2    = c[6:2];
        ld_imm = {c[3:2], c[12], c[6:4], 2'b00};
        st_imm = {c[8:7], c[12:9], 2'b00};
    end

    always_comb begin
        word_o = '0;
        bad_o  = 1'b0;
        unique case (c[15:13])
            3'b000: begin
                word_o = build_i({7'b0000000, c[6:2]}, rd, F3_SLL, rd, OPC_IMM);
                bad_o  = c[12] || (rd == REG_ZERO);
            end
            3'b010: word_o = build_i({4'b0, ld_imm}, REG_SP, F3_WORD, rd, OPC_LOAD);
            3'b100: begin
                // overlap order: register jump before move, break before link-jump before add
                if (!c[12]) begin
                    if (rs2 == REG_ZERO)
                        word_o = build_i(12'd0, rd, F3_ADD, REG_ZERO, OPC_JALR);
                    else
                        word_o = build_r(7'd0, rs2, REG_ZERO, F3_ADD, rd);
                end else begin
                    if (rs2 == REG_ZERO && rd == REG_ZERO)
                        word_o = WORD_BREAK;
                    else if (rs2 == REG_ZERO)
                        word_o = build_i(12'd0, rd, F3_ADD, REG_LINK, OPC_JALR);
                    else
                        word_o = build_r(7'd0, rs2, rd, F3_ADD, rd);
                end
            end
            3'b110: word_o = build_s({4'b0, st_imm}, rs2, REG_SP, F3_WORD);
            default: bad_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
    import rvc_pkg::*;
(
    input  logic [31:0] fetch_i,
    output logic [31:0] instr_o,
    output logic        illegal_o
);

    localparam int NQ = 3;

    word_t q_word [NQ];
    logic  q_bad  [NQ];

    rvc_q0_dec u_q0 (.c(fetch_i[15:2]), .word_o(q_word[0]), .bad_o(q_bad[0]));
    rvc_q1_dec u_q1 (.c(fetch_i[15:2]), .word_o(q_word[1]), .bad_o(q_bad[1]));
    rvc_q2_dec u_q2 (.c(fetch_i[15:2]), .word_o(q_word[2]), .bad_o(q_bad[2]));

    word_t sel_word;
    logic  sel_bad;

    always_comb begin
        unique case (fetch_i[1:0])
            2'b00: begin sel_word = q_word[0]; sel_bad = q_bad[0]; end
            2'b01: begin sel_word = q_word[1]; sel_bad = q_bad[1]; end
            2'b10: begin sel_word = q_word[2]; sel_bad = q_bad[2]; end
            default: begin sel_word = fetch_i; sel_bad = 1'b0; end
        endcase
    end

    always_comb begin
        illegal_o = sel_bad;
        instr_o   = sel_bad ? {{PADW{1'b0}}, fetch_i[CLEN-1:0]} : sel_word;
    end

endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
    input logic [31:0] fetch_i,
    input logic [31:0] instr_o,
    input logic        illegal_o
);

    logic is_comp;
    logic q0_mem;
    logic q1_prime;

    always_comb begin
        is_comp  = (fetch_i[1:0] != 2'b11);
        q0_mem   = (fetch_i[1:0] == 2'b00) &&
                   (fetch_i[15:13] == 3'b010 || fetch_i[15:13] == 3'b110);
        q1_prime = (fetch_i[1:0] == 2'b01) && fetch_i[15];
    end

    always_comb begin
        if (!$isunknown({fetch_i, instr_o, illegal_o})) begin
            a_r1_passthrough: assert (is_comp || (instr_o == fetch_i && !illegal_o));
            a_r2_raw_on_illegal: assert (!illegal_o || instr_o == {16'h0, fetch_i[15:0]});
            a_r2_zero_parcel: assert (fetch_i[15:0] != 16'h0 || illegal_o);
            a_r2_full_opcode: assert (!is_comp || illegal_o || instr_o[1:0] == 2'b11);
            // R3: loads/stores in quadrant 00 and quadrant-01 functions 100..111 use x8..x15 as base
            a_r3_base_window: assert (!(q0_mem || (q1_prime && fetch_i[14:13] != 2'b01))
                                      || illegal_o || instr_o[19:18] == 2'b01);
            a_r7_link_x1: assert (!(fetch_i[1:0] == 2'b01 && fetch_i[15:13] == 3'b001)
                                  || instr_o[11:0] == 12'h0EF);
            a_r14_q2_odd_func: assert (!(fetch_i[1:0] == 2'b10 && fetch_i[13]) || illegal_o);
        end
    end

endmodule

bind rvc_expander rvc_expander_chk u_chk (
    .fetch_i  (fetch_i),
    .instr_o  (instr_o),
    .illegal_o(illegal_o)
);

// File: tb/rvc_expander_tb.sv
`timescale 1ns/1ps
module rvc_expander_tb;

    localparam time TCK      = 4ns;
    localparam int  WD_TICKS = 150000;

    logic        clk = 1'b0;
    logic [31:0] fetch;
    logic [31:0] instr;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(TCK/2) clk = ~clk;

    rvc_expander u_dut (.fetch_i(fetch), .instr_o(instr), .illegal_o(illegal));

    typedef struct packed {
        logic [31:0] stim;
        logic [31:0] want;
        logic        bad;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t TBL [NV] = '{
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'd1},   // R1 full word
        '{32'h00A3_0293, 32'h00A3_0293, 1'b0, 4'd1},   // R1 addi x5,x6,10
        '{32'hABCD_0001, 32'h0000_0013, 1'b0, 4'd1},   // R1 upper half ignored (nop)
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 4'd2},   // R2 all-zero parcel
        '{32'hABCD_2000, 32'h0000_2000, 1'b1, 4'd2},   // R2 raw parcel on illegal
        '{32'h0000_12A4, 32'h1681_0493, 1'b0, 4'd4},   // R4 addi x9,x2,360
        '{32'h0000_0004, 32'h0000_0004, 1'b1, 4'd4},   // R4 zero immediate
        '{32'h0000_49E8, 32'h0545_A503, 1'b0, 4'd5},   // R5 lw x10,84(x11)
        '{32'h0000_C050, 32'h00C4_2223, 1'b0, 4'd5},   // R5 sw x12,4(x8)
        '{32'h0000_12F5, 32'hFFD2_8293, 1'b0, 4'd6},   // R6 addi x5,x5,-3
        '{32'h0000_4005, 32'h0000_4005, 1'b1, 4'd6},   // R6 load-immediate rd=0
        '{32'h0000_43FD, 32'h01F0_0393, 1'b0, 4'd6},   // R6 addi x7,x0,31
        '{32'h0000_9BFD, 32'hFFF7_F793, 1'b0, 4'd3},   // R3 andi x15,x15,-1
        '{32'h0000_3FFD, 32'hFFFF_F0EF, 1'b0, 4'd7},   // R7 jal x1,-2
        '{32'h0000_A991, 32'h4540_006F, 1'b0, 4'd7},   // R7 jal x0,0x454
        '{32'h0000_DABD, 32'hF606_8BE3, 1'b0, 4'd8},   // R8 beq x13,x0,-138
        '{32'h0000_E009, 32'h0004_1163, 1'b0, 4'd8},   // R8 bne x8,x0,2
        '{32'h0000_7179, 32'hFD01_0113, 1'b0, 4'd9},   // R9 addi x2,x2,-48
        '{32'h0000_6101, 32'h0000_6101, 1'b1, 4'd9},   // R9 stack adjust zero
        '{32'h0000_7305, 32'hFFFE_1337, 1'b0, 4'd9},   // R9 lui x6,0xFFFE1
        '{32'h0000_6301, 32'h0000_6301, 1'b1, 4'd9},   // R9 lui zero imm
        '{32'h0000_871D, 32'h4077_5713, 1'b0, 4'd10},  // R10 srai x14,x14,7
        '{32'h0000_9305, 32'h0000_9305, 1'b1, 4'd10},  // R10 shift bit12 set
        '{32'h0000_01FE, 32'h01F1_9193, 1'b0, 4'd10},  // R10 slli x3,x3,31
        '{32'h0000_0006, 32'h0000_0006, 1'b1, 4'd10},  // R10 slli rd=0
        '{32'h0000_8C1D, 32'h40F4_0433, 1'b0, 4'd11},  // R11 sub x8,x8,x15
        '{32'h0000_8CC9, 32'h00A4_E4B3, 1'b0, 4'd11},  // R11 or x9,x9,x10
        '{32'h0000_9C1D, 32'h0000_9C1D, 1'b1, 4'd11},  // R11 bit12 set
        '{32'h0000_8282, 32'h0002_8067, 1'b0, 4'd12},  // R12 jalr x0,0(x5)
        '{32'h0000_829A, 32'h0060_02B3, 1'b0, 4'd12},  // R12 add x5,x0,x6
        '{32'h0000_9002, 32'h0010_0073, 1'b0, 4'd12},  // R12 ebreak
        '{32'h0000_9382, 32'h0003_80E7, 1'b0, 4'd12},  // R12 jalr x1,0(x7)
        '{32'h0000_939A, 32'h0063_83B3, 1'b0, 4'd12},  // R12 add x7,x7,x6
        '{32'h0000_5A3A, 32'h0AC1_2A03, 1'b0, 4'd13},  // R13 lw x20,172(x2)
        '{32'h0000_D2FE, 32'h07F1_2223, 1'b0, 4'd13},  // R13 sw x31,100(x2)
        '{32'h0000_2000, 32'h0000_2000, 1'b1, 4'd14},  // R14 quadrant 00 func 001
        '{32'h0000_E002, 32'h0000_E002, 1'b1, 4'd14}   // R14 quadrant 10 func 111
    };

    task automatic check(input logic [31:0] got_w, input logic got_b,
                         input logic [31:0] exp_w, input logic exp_b,
                         input logic [3:0] req, input logic [31:0] stim);
        n_checks++;
        if (got_w !== exp_w || got_b !== exp_b) begin
            n_fail++;
            $display("FAIL R%0d stim=%08h actual=%08h/%0b expected=%08h/%0b",
                     req, stim, got_w, got_b, exp_w, exp_b);
        end
    endtask

    initial begin
        fetch = 32'h0000_0000;
        @(negedge clk);
        #1;
        // idle input right after start: zero parcel must flag (R2)
        check(instr, illegal, 32'h0, 1'b1, 4'd2, fetch);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fetch = TBL[i].stim;
            #1;
            check(instr, illegal, TBL[i].want, TBL[i].bad, TBL[i].req, TBL[i].stim);
        end

        // R2 sweep: every compressed parcel yields raw parcel or a full opcode
        begin
            int bad_sweep = 0;
            logic [31:0] first_w = '0;
            logic [31:0] first_s = '0;
            for (int p = 0; p < 65536; p++) begin
                fetch = {16'h5A5A, p[15:0]};
                #1;
                if (p[1:0] != 2'b11) begin
                    if (illegal ? (instr !== {16'h0, p[15:0]}) : (instr[1:0] !== 2'b11)) begin
                        if (bad_sweep == 0) begin first_w = instr; first_s = fetch; end
                        bad_sweep++;
                    end
                end else if (instr !== fetch || illegal !== 1'b0) begin
                    if (bad_sweep == 0) begin first_w = instr; first_s = fetch; end
                    bad_sweep++;
                end
            end
            n_checks++;
            if (bad_sweep != 0) begin
                n_fail++;
                $display("FAIL R2 sweep stim=%08h actual=%08h expected=raw parcel or full opcode (%0d bad)",
                         first_s, first_w, bad_sweep);
            end
        end

        // R12 order: x0 as add target with nonzero rs2 is still add, not break
        @(negedge clk);
        fetch = 32'h0000_900A;   // c.add x0,x2 -> add x0,x0,x2
        #1;
        check(instr, illegal, 32'h0020_0033, 1'b0, 4'd12, fetch);

        // R3 highest prime register on both fields: c.and x15,x15
        @(negedge clk);
        fetch = 32'h0000_8FFD;
        #1;
        check(instr, illegal, 32'h00F7_F7B3, 1'b0, 4'd3, fetch);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WD_TICKS) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule